// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that finishes every instruction in the clock cycle that fetches it. It supports register-to-register arithmetic, logic and shifts, word loads and stores, a branch taken when two registers are equal, and an unconditional jump. The core holds the program counter, the next-address selection, a 32-entry register file, the immediate sign extender, the ALU and the instruction decoder.

The core drives two memories, and both read combinationally. An instruction port presents the current PC and takes back the instruction word in the same cycle. A data port carries an address, write data, a write enable and the returned read data. The PC, the register file and the data memory all update on the same rising clock edge. A program therefore runs one instruction per cycle with no stalls.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and dmem_we_o is 0. The first instruction after reset is fetched from address 0.
- R2: Register 0 always reads as zero. A write that targets it leaves it at zero.
- R3: Opcode 000000 writes R[rd] at the clock edge that ends the cycle. The result depends on funct: 100000 gives rs+rt, 100010 gives rs-rt, 100100 gives AND, 100101 gives OR, 100110 gives XOR, 100111 gives NOR, 101010 gives 1 if rs<rt as signed numbers and 0 otherwise, 000000 gives rt shifted left by shamt[10:6], and 000010 gives rt shifted right logically by shamt. Any other funct writes no register.
- R4: Opcode 100011 (load) drives dmem_addr_o with R[rs] plus the sign-extended offset in [15:0]. It writes dmem_rdata_i into R[rt].
- R5: Opcode 101011 (store) raises dmem_we_o. It drives dmem_addr_o with R[rs] plus the sign-extended offset and drives dmem_wdata_o with R[rt]. It writes no register.
- R6: Opcode 000100 (branch) compares R[rs] with R[rt]. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4. Negative offsets branch backward.
- R7: Opcode 000010 (jump) loads the PC with {PC+4[31:28], instr[25:0], 2'b00}.
- R8: Any other opcode writes neither a register nor memory, and the PC advances by 4.
- R9: After every instruction that is neither a branch nor a jump, the next PC is PC+4.
- R10: dmem_we_o is 1 only in a cycle that executes a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Current PC, the instruction fetch address |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_rdata_i | input | 32 | Data word read at dmem_addr_o |

## Verification
The assertions assume that the instruction word and the load data are valid in the same cycle as the address that selects them. They also assume that the data memory takes a store on the same edge that updates the PC. The bench's memory models are combinational arrays indexed by the core's outputs, so both assumptions hold for every cycle. The stimulus uses only word-aligned offsets and keeps every data address inside the 64-word data array, so no access falls outside the modelled memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_we;
    logic    mem_rd;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  alu_op_e r_op;
  logic    r_ok;

  // funct decode for register-register ops
  always_comb begin
    r_ok = 1'b1;
    r_op = ALU_ADD;
    case (funct_i)
      FN_ADD:  r_op = ALU_ADD;
      FN_SUB:  r_op = ALU_SUB;
      FN_AND:  r_op = ALU_AND;
      FN_OR:   r_op = ALU_OR;
      FN_XOR:  r_op = ALU_XOR;
      FN_NOR:  r_op = ALU_NOR;
      FN_SLT:  r_op = ALU_SLT;
      FN_SLL:  r_op = ALU_SLL;
      FN_SRL:  r_op = ALU_SRL;
      default: r_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OPC_RTYPE: begin
        ctrl_o.reg_we = r_ok;
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.alu_op = r_op;
      end
      OPC_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OPC_J:   ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [4:0]      shamt_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;  // hard-wired zero entry

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs[g] <= '0;
      else if (we_i && wa_i == AW'(g))   regs[g] <= wd_i;
    end
  end

  assign rdata_a_o = regs[ra_i];
  assign rdata_b_o = regs[rb_i];

  AST_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0 && wa_i == ra_i) |=> (rdata_a_o == $past(wd_i) || ra_i != $past(wa_i))); // R3
  AST_R0_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |-> (rdata_a_o == '0)); // R2
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [15:0]     off_i,
  input  logic [25:0]     tgt_i,
  input  logic            branch_i,
  input  logic            zero_i,
  input  logic            jump_i,
  output logic [XLEN-1:0] next_o
);
  logic [XLEN-1:0] pc4, br_tgt, j_tgt, off_ext;

  assign pc4     = pc_i + XLEN'(4);
  assign off_ext = {{(XLEN-16){off_i[15]}}, off_i};
  assign br_tgt  = pc4 + (off_ext << 2);
  assign j_tgt   = {pc4[XLEN-1:28], tgt_i, 2'b00};

  always_comb begin
    if (jump_i)                  next_o = j_tgt;
    else if (branch_i && zero_i) next_o = br_tgt;
    else                         next_o = pc4;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic [5:0]      op, funct;
  logic [AW-1:0]   rs, rt, rd, rf_wa;
  logic [4:0]      shamt;
  logic [15:0]     imm;
  logic [XLEN-1:0] imm_ext, ra_val, rb_val, alu_b, alu_y, rf_wd;
  logic            alu_zero;
  ctrl_t           ctrl;

  assign op    = imem_rdata_i[31:26];
  assign rs    = AW'(imem_rdata_i[25:21]);
  assign rt    = AW'(imem_rdata_i[20:16]);
  assign rd    = AW'(imem_rdata_i[15:11]);
  assign shamt = imem_rdata_i[10:6];
  assign funct = imem_rdata_i[5:0];
  assign imm   = imem_rdata_i[15:0];

  sc_ctrl u_ctrl (
    .op_i    (op),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  assign rf_wa = ctrl.dst_rd ? rd : rt;
  assign rf_wd = ctrl.mem_rd ? dmem_rdata_i : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (rs),
    .rb_i      (rt),
    .rdata_a_o (ra_val),
    .rdata_b_o (rb_val),
    .we_i      (ctrl.reg_we),
    .wa_i      (rf_wa),
    .wd_i      (rf_wd)
  );

  assign imm_ext = {{(XLEN-16){imm[15]}}, imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rb_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a_i     (ra_val),
    .b_i     (alu_b),
    .shamt_i (shamt),
    .op_i    (ctrl.alu_op),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  sc_next_pc #(.XLEN(XLEN)) u_npc (
    .pc_i     (pc_q),
    .off_i    (imm),
    .tgt_i    (imem_rdata_i[25:0]),
    .branch_i (ctrl.branch),
    .zero_i   (alu_zero),
    .jump_i   (ctrl.jump),
    .next_o   (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rb_val;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;

  AST_STORE_NO_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !ctrl.reg_we); // R5
  AST_WE_ONLY_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (op == OPC_SW)); // R10
  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OPC_BEQ && op != OPC_J) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R9
  AST_JUMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OPC_J) |=> (pc_q[27:2] == $past(imem_rdata_i[25:0]))); // R7
  AST_BEQ_NT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OPC_BEQ && ra_val != rb_val) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R6
  AST_UNK_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OPC_RTYPE && op != OPC_LW && op != OPC_SW && op != OPC_BEQ && op != OPC_J)
      |-> (!ctrl.reg_we && !dmem_we_o)); // R8
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 320;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_rdata_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;

  logic [31:0] imem [256];
  logic [31:0] dmem [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  string       pc_tag;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wp = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_core dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_rdata_i (imem_rdata_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  assign imem_rdata_i = imem[imem_addr_o[9:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[7:2]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[7:2]] <= dmem_wdata_o;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: one instruction per call, from the requirements
  task automatic step();
    logic [31:0] ins, rsv, rtv, sx, nxt, addr, wd;
    logic [5:0]  op, fn;
    int          rs, rt, rd, sh, wa;
    logic        wr, we;
    string       tag;
    ins = imem[m_pc[9:2]];
    chk(pc_tag, imem_addr_o, m_pc);
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]); sh = int'(ins[10:6]);
    rsv = m_rf[rs]; rtv = m_rf[rt];
    sx  = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 4; wr = 1'b0; we = 1'b0; wa = 0; wd = '0; tag = "R9";
    case (op)
      6'b000000: begin
        wr = 1'b1; wa = rd;
        case (fn)
          6'b100000: wd = rsv + rtv;
          6'b100010: wd = rsv - rtv;
          6'b100100: wd = rsv & rtv;
          6'b100101: wd = rsv | rtv;
          6'b100110: wd = rsv ^ rtv;
          6'b100111: wd = ~(rsv | rtv);
          6'b101010: wd = ($signed(rsv) < $signed(rtv)) ? 32'd1 : 32'd0;
          6'b000000: wd = rtv << sh;
          6'b000010: wd = rtv >> sh;
          default:   wr = 1'b0;
        endcase
      end
      6'b100011: begin
        addr = rsv + sx;
        chk("R4", dmem_addr_o, addr);
        wr = 1'b1; wa = rt; wd = dmem[addr[7:2]];
      end
      6'b101011: begin
        addr = rsv + sx; we = 1'b1;
        chk("R5", dmem_addr_o, addr);
        chk(rt == 0 ? "R2" : "R5", dmem_wdata_o, rtv);
      end
      6'b000100: begin
        tag = "R6";
        if (rsv == rtv) nxt = m_pc + 4 + (sx << 2);
      end
      6'b000010: begin
        tag = "R7";
        nxt = {m_pc[31:28] + 4'(0), ins[25:0], 2'b00};
        nxt[31:28] = (m_pc + 32'd4) >> 28;
      end
      default: tag = "R8";
    endcase
    chk(op == 6'b101011 ? "R10" : (tag == "R8" ? "R8" : "R10"), {31'b0, dmem_we_o}, {31'b0, we});
    if (wr && wa != 0) m_rf[wa] = wd;
    pc_tag = tag;
    m_pc = nxt;
  endtask

  initial begin
    logic [5:0] fns [9];
    int         k;
    fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b100110,
            6'b100111, 6'b101010, 6'b000000, 6'b000010};
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;
    for (int i = 0; i < 64; i++)  dmem[i] = 32'h0;
    for (int i = 0; i < 32; i++)  m_rf[i] = 32'h0;
    dmem[0] = 32'd5;        dmem[1] = 32'd3;
    dmem[2] = 32'hFFFF_FFF0; dmem[3] = 32'h0000_0010;
    dmem[4] = 32'h7FFF_FFFF; dmem[5] = 32'h8000_0001;
    dmem[6] = 32'h1234_5678; dmem[7] = 32'h1234_5678;
    dmem[8] = 32'd64;       dmem[15] = 32'hCAFE_F00D;

    emit(enc_i(6'b100011, 0, 7, 32));   // r7 = 64
    emit(enc_i(6'b100011, 7, 8, -4));   // negative offset: word 15
    emit(enc_i(6'b101011, 7, 8, 16));   // store to word 20
    k = 0;
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 9; f++) begin
        emit(enc_i(6'b100011, 0, 1, 8*p));
        emit(enc_i(6'b100011, 0, 2, 8*p + 4));
        emit(enc_r(1, 2, 3, 3 + 7*p, fns[f]));
        emit(enc_i(6'b101011, 0, 3, 4*(24 + (k % 32))));
        k++;
      end
    end
    emit(enc_r(1, 2, 0, 0, 6'b100000));       // write to r0
    emit(enc_i(6'b101011, 0, 0, 224));
    emit(enc_i(6'b001000, 1, 3, 5));          // unknown opcode
    emit(enc_r(1, 2, 3, 0, 6'b111111));       // unknown funct
    emit(enc_i(6'b101011, 0, 3, 228));
    emit(enc_i(6'b000100, 7, 8, 1));          // not taken
    emit(enc_i(6'b101011, 0, 7, 232));
    emit(enc_i(6'b000100, 1, 2, 1));          // taken, skips next
    emit(enc_i(6'b101011, 0, 8, 236));
    emit(enc_i(6'b101011, 0, 1, 240));
    k = wp;
    emit({6'b000010, 26'(k + 3)});             // jump forward
    emit(enc_i(6'b101011, 0, 2, 244));        // backward branch target
    emit({6'b000010, 26'(k + 4)});
    emit(enc_i(6'b000100, 0, 0, -3));         // backward branch
    emit({6'b000010, 26'(k + 4)});             // halt loop

    m_pc = 32'h0;
    pc_tag = "R1";
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", imem_addr_o, 32'h0);
      chk("R1", {31'b0, dmem_we_o}, 32'h0);
    end
    rst_ni = 1'b1;
    repeat (RUN_CYCLES) begin
      #1;
      step();
      @(negedge clk_i);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule